// File: doc/BRIEF.md
# Touchscreen ADC serial host controller

This block runs the host side of a serial link to a touchscreen converter. A request carries a channel number, a resolution choice, an input-mode bit and two power-down bits. Once the controller accepts a request, it drives chip select low. It sends an eight-bit command MSB first on the data-out line (`mosi`) and toggles a divided serial clock whose high and low halves are each a whole number of system clocks. It then collects the returned sample from `miso` on the rising serial-clock edges and presents it as a 12-bit word with a one-cycle valid strobe.

The divider half-period comes from the system clock period, so the serial clock stays at or above 200 ns high and 200 ns low. The chip-select-to-first-edge time also stays at or above 100 ns. In isolated mode every conversion is one chip-select frame: 24 serial clocks at 12 bits, or 20 at 8 bits. With `overlap_en` set, the controller accepts the next request at a fixed point of the current conversion. It begins the next command while the last data bits of the previous one are still arriving, which gives 15 serial clocks per 12-bit conversion and 11 per 8-bit conversion.

Top module: `touch_adc_host`

## Requirements
- R1: The command byte goes out MSB first as {1, chan[2:0], res8, single_ended, pd_mode[1:0]}: a constant 1, then the channel from bit 2 down, then the resolution bit (1 = 8-bit), then the input-mode bit, then the two power-down bits. The leading 1 is on `mosi` from the first system cycle after acceptance.
- R2: `sclk` is low whenever `cs_n` is high. Every high and every low interval of `sclk` lasts at least ceil(200 ns / clock period) system clocks (20 at the default 10 ns).
- R3: At least 100 ns pass between `cs_n` falling and the first rising edge of `sclk`.
- R4: `mosi` changes only on the falling edges of `sclk`. It is stable for at least 100 ns before each rising edge and for at least 50 ns after it.
- R5: In a 12-bit isolated frame, `cs_n` stays low for exactly 24 rising `sclk` edges. The result bits are taken from `miso` on rising edges 10 to 21, counted from the command's leading 1, MSB first.
- R6: In an 8-bit isolated frame, `cs_n` stays low for exactly 20 rising edges. The result bits are taken on rising edges 10 to 17, MSB first.
- R7: Each conversion produces exactly one `res_valid` pulse of one system cycle. A 12-bit result is the straight-binary value received. An 8-bit result is placed in `res_data[11:4]` with zeros below when JUSTIFY_RIGHT is 0 (the default), and in `res_data[7:0]` when it is 1.
- R8: `req_ready` is high whenever `cs_n` is high. A `start` given while `req_ready` is low is ignored: no extra command is sent, and the frame keeps its length.
- R9: With `overlap_en` high, a request offered at the overlap point sends its leading 1 on the 16th rising edge after the previous command's leading 1 if that command was 12-bit, or on the 12th if it was 8-bit. `cs_n` stays low throughout.
- R10: With `overlap_en` high and no request at the overlap point, the frame ends with its isolated length.
- R11: After reset, `cs_n` is high, `sclk`, `mosi` and `res_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken when req_ready is high |
| chan | input | 3 | Channel select field |
| res8 | input | 1 | 1 selects an 8-bit conversion, 0 a 12-bit one |
| single_ended | input | 1 | Input-mode bit placed in the command |
| pd_mode | input | 2 | Power-down bits placed in the command |
| overlap_en | input | 1 | Enables back-to-back overlapped conversions |
| req_ready | output | 1 | High when a request would be accepted this cycle |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Divided serial clock to the converter |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Result data from the converter |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_data | output | 12 | Result word |

## Verification
In overlapped operation, two things happen on the same serial-clock falling edge. The next command is loaded, and the previous conversion's data bits are still arriving. A few edges later, the receiver finishes the old result on the same edge that advances the new command. The bench provokes both with runs of up to five overlapped requests of mixed resolution, each offered the moment `req_ready` rises. A converter model in the bench decodes every command and returns a distinct value per conversion. The bench checks each decoded command byte, each result value, the spacing of the leading 1 bits and the total edge count of the chip-select frame.

// File: rtl/tadc_pkg.sv
package tadc_pkg;
  localparam int CMD_BITS    = 8;
  localparam int RES_BITS    = 12;
  localparam int FULL_FRAME  = 24;
  localparam int SHORT_CUT   = 4;
  localparam int PIPE_PERIOD = 15;
  localparam int FIRST_DATA  = 10;
  localparam int POS_W       = $clog2(FULL_FRAME + 1);

  // smallest half-period in system clocks meeting both the level and the setup minimum
  function automatic int half_cycles(int clk_ns, int level_ns, int setup_ns);
    int a;
    int b;
    a = (level_ns + clk_ns - 1) / clk_ns;
    b = (setup_ns + clk_ns - 1) / clk_ns;
    if (a < b) a = b;
    if (a < 2) a = 2;
    return a;
  endfunction

  function automatic logic [CMD_BITS-1:0] make_cmd(logic [2:0] ch, logic m8, logic se,
                                                   logic [1:0] pd);
    return {1'b1, ch, m8, se, pd};
  endfunction

  function automatic logic [POS_W-1:0] frame_len(logic m8);
    return m8 ? POS_W'(FULL_FRAME - SHORT_CUT) : POS_W'(FULL_FRAME);
  endfunction

  function automatic logic [POS_W-1:0] overlap_pos(logic m8);
    return m8 ? POS_W'(PIPE_PERIOD - SHORT_CUT) : POS_W'(PIPE_PERIOD);
  endfunction

  function automatic logic [POS_W-1:0] last_bit(logic m8);
    return m8 ? POS_W'(FIRST_DATA + RES_BITS - SHORT_CUT - 1) : POS_W'(FIRST_DATA + RES_BITS - 1);
  endfunction

  function automatic logic [RES_BITS-1:0] justify(logic [RES_BITS-1:0] sh, logic m8, logic right);
    if (!m8) return sh;
    if (right) return {4'b0000, sh[7:0]};
    return {sh[7:0], 4'b0000};
  endfunction
endpackage

// File: rtl/tadc_clkgen.sv
module tadc_clkgen #(
  parameter int HALF_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          wrap_w;

  assign wrap_w   = run && (cnt_q == CW'(HALF_CYC - 1));
  assign rise_evt = wrap_w && !sclk;
  assign fall_evt = wrap_w && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (wrap_w) begin
      cnt_q <= '0;
      sclk  <= ~sclk;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/tadc_rx.sv
module tadc_rx
  import tadc_pkg::*;
#(
  parameter bit JUSTIFY_RIGHT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_evt,
  input  logic                miso,
  input  logic                conv_start,
  input  logic                conv_m8,
  input  logic [POS_W-1:0]    cur_pos,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data
);
  logic                act_q, rmode_q, pend_q, pmode_q;
  logic [POS_W-1:0]    re_q, e_w;
  logic [RES_BITS-1:0] sh_q, sh_next;
  logic                samp_w, done_w;

  assign e_w     = re_q + POS_W'(1);
  assign sh_next = {sh_q[RES_BITS-2:0], miso};
  assign samp_w  = act_q && rise_evt && (e_w >= POS_W'(FIRST_DATA)) && (e_w <= last_bit(rmode_q));
  assign done_w  = act_q && rise_evt && (e_w == last_bit(rmode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      rmode_q   <= 1'b0;
      pend_q    <= 1'b0;
      pmode_q   <= 1'b0;
      re_q      <= '0;
      sh_q      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= done_w;
      if (done_w) res_data <= justify(sh_next, rmode_q, JUSTIFY_RIGHT);
      if (conv_start) begin
        if (!act_q) begin
          act_q   <= 1'b1;
          re_q    <= '0;
          rmode_q <= conv_m8;
        end else begin
          pend_q  <= 1'b1;
          pmode_q <= conv_m8;
        end
      end else if (act_q && rise_evt) begin
        re_q <= e_w;
        if (samp_w) sh_q <= sh_next;
        if (done_w) begin
          if (pend_q) begin
            // hand over to the command already in flight, aligned to its edge count
            re_q    <= cur_pos + POS_W'(1);
            rmode_q <= pmode_q;
            pend_q  <= 1'b0;
          end else begin
            act_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/touch_adc_host.sv
module touch_adc_host
  import tadc_pkg::*;
#(
  parameter int CLK_PERIOD_NS    = 10,
  parameter int DCLK_MIN_HALF_NS = 200,
  parameter int CS_SETUP_NS      = 100,
  parameter bit JUSTIFY_RIGHT    = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          chan,
  input  logic                res8,
  input  logic                single_ended,
  input  logic [1:0]          pd_mode,
  input  logic                overlap_en,
  output logic                req_ready,
  output logic                cs_n,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data
);
  localparam int HALF_CYC = half_cycles(CLK_PERIOD_NS, DCLK_MIN_HALF_NS, CS_SETUP_NS);

  logic                run_q, mode8_q;
  logic [POS_W-1:0]    pos_q;
  logic [CMD_BITS-1:0] tx_q;
  logic                rise_evt, fall_evt;
  logic                overlap_pt_w, frame_end_w, accept_w;
  logic [15:0]         half_w;

  assign half_w = 16'(HALF_CYC);

  tadc_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .sclk     (sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  assign overlap_pt_w = run_q && overlap_en && fall_evt && (pos_q == overlap_pos(mode8_q));
  assign frame_end_w  = run_q && fall_evt && (pos_q == frame_len(mode8_q));
  assign req_ready    = !run_q || overlap_pt_w;
  assign accept_w     = start && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mode8_q <= 1'b0;
      pos_q   <= '0;
      tx_q    <= '0;
    end else if (accept_w) begin
      run_q   <= 1'b1;
      mode8_q <= res8;
      pos_q   <= '0;
      tx_q    <= make_cmd(chan, res8, single_ended, pd_mode);
    end else if (run_q) begin
      if (rise_evt) pos_q <= pos_q + POS_W'(1);
      if (fall_evt) begin
        tx_q <= {tx_q[CMD_BITS-2:0], 1'b0};
        if (frame_end_w) run_q <= 1'b0;
      end
    end
  end

  assign cs_n = !run_q;
  assign mosi = tx_q[CMD_BITS-1];

  tadc_rx #(.JUSTIFY_RIGHT(JUSTIFY_RIGHT)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_evt   (rise_evt),
    .miso       (miso),
    .conv_start (accept_w),
    .conv_m8    (res8),
    .cur_pos    (pos_q),
    .res_valid  (res_valid),
    .res_data   (res_data)
  );
endmodule

// File: rtl/tadc_host_chk.sv
module tadc_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        cs_n,
  input logic        sclk,
  input logic        mosi,
  input logic        res_valid,
  input logic        run_q,
  input logic [4:0]  pos_q,
  input logic        accept_w,
  input logic [15:0] half_w
);
  logic        sclk_d;
  logic [15:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      if (sclk != sclk_d) hold_cnt <= '0;
      else if (hold_cnt != 16'hFFFF) hold_cnt <= hold_cnt + 16'd1;
    end
  end

  AST_START_BIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> mosi); // R1
  AST_DCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R2
  AST_DCLK_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_d) |-> (hold_cnt >= half_w - 16'd1)); // R2
  AST_CS_FALL_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk); // R3
  AST_DIN_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && sclk_d) |-> $stable(mosi)); // R4
  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pos_q <= 5'd24)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> req_ready); // R8
endmodule

bind touch_adc_host tadc_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .res_valid (res_valid),
  .run_q     (run_q),
  .pos_q     (pos_q),
  .accept_w  (accept_w),
  .half_w    (half_w)
);

// File: tb/touch_adc_host_tb.sv
module touch_adc_host_tb;
  localparam int HALF_EXP = 20;   // 200 ns at 10 ns
  localparam int CSS_EXP  = 10;   // 100 ns
  localparam int HOLD_EXP = 5;    // 50 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] chan = '0;
  logic res8 = 1'b0, single_ended = 1'b0, overlap_en = 1'b0;
  logic [1:0] pd_mode = '0;
  logic req_ready, cs_n, sclk, mosi, res_valid;
  logic miso = 1'b0;
  logic [11:0] res_data;

  always #5 clk = ~clk;

  touch_adc_host u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .res8(res8),
    .single_ended(single_ended), .pd_mode(pd_mode), .overlap_en(overlap_en),
    .req_ready(req_ready), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .res_valid(res_valid), .res_data(res_data)
  );

  int checks = 0, errors = 0;
  int nissued = 0, nrcv = 0, nframes = 0, nres = 0;
  logic [7:0]  exp_cmd [0:63];
  logic        exp_m8  [0:63];
  logic [7:0]  rcv_cmd [0:63];
  int          rcv_frame [0:63];
  int          rcv_edge  [0:63];
  int          frame_edges [0:63];
  logic [11:0] res_got [0:63];

  function automatic logic [11:0] mval(int i);
    return 12'((i * 1237 + 291) & 4095);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // converter model: decodes commands on rising edges, shifts data on falling edges
  int m_bits = 0, m_edge = 0;
  logic [7:0]  m_sh;
  logic [15:0] m_out = '0;
  logic [11:0] mv;
  always @(sclk or cs_n) begin
    if (cs_n) begin
      if (m_edge > 0) begin
        frame_edges[nframes] = m_edge;
        nframes++;
        m_edge = 0;
      end
      m_bits = 0;
      m_out  = '0;
    end else if (sclk) begin
      m_edge++;
      if (m_bits == 0) begin
        if (mosi) begin
          m_bits = 1;
          m_sh = 8'h01;
          rcv_edge[nrcv] = m_edge;
        end
      end else begin
        m_sh = {m_sh[6:0], mosi};
        m_bits++;
        if (m_bits == 8) begin
          rcv_cmd[nrcv] = m_sh;
          rcv_frame[nrcv] = nframes;
          mv = mval(nrcv);
          m_out = m_sh[3] ? {1'b0, mv[7:0], 7'b0} : {1'b0, mv, 3'b0};
          nrcv++;
          m_bits = 0;
        end
      end
    end else begin
      miso = m_out[15];
      m_out = m_out << 1;
    end
  end

  // timing and result monitor, away from the active edge
  int cyc = 0, last_edge = -1000, last_rise = -1000, last_din = -1000, cs_fall_t = -1000;
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r7 = 0;
  logic p_sclk = 1'b0, p_mosi = 1'b0, p_cs = 1'b1, p_valid = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!cs_n && p_cs) cs_fall_t = cyc;
      if (cs_n && sclk) v_r2++;
      if (sclk && !p_sclk) begin
        if (cyc - last_edge < HALF_EXP) v_r2++;
        if (cyc - cs_fall_t < CSS_EXP) v_r3++;
        if (cyc - last_din < CSS_EXP) v_r4++;
        last_edge = cyc;
        last_rise = cyc;
      end
      if (!sclk && p_sclk) begin
        if (cyc - last_edge < HALF_EXP) v_r2++;
        last_edge = cyc;
      end
      if (mosi != p_mosi) begin
        if (cyc - last_rise < HOLD_EXP) v_r4++;
        if (sclk) v_r4++;
        last_din = cyc;
      end
      if (res_valid) begin
        if (p_valid) v_r7++;
        else begin
          res_got[nres] = res_data;
          nres++;
        end
      end
    end
    p_sclk = sclk; p_mosi = mosi; p_cs = cs_n; p_valid = res_valid;
  end

  task automatic issue(input logic [2:0] ch, input logic m8, input logic se, input logic [1:0] pd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    chan = ch; res8 = m8; single_ended = se; pd_mode = pd; start = 1'b1;
    exp_cmd[nissued] = {1'b1, ch, m8, se, pd};
    exp_m8[nissued] = m8;
    nissued++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nres, nissued);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sum;
    int m[0:4];
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1, "R11 cs_n in reset", cs_n, 1);
    chk(sclk == 1'b0 && mosi == 1'b0, "R11 sclk/mosi in reset", {sclk, mosi}, 0);
    chk(res_valid == 1'b0, "R11 res_valid in reset", res_valid, 0);
    chk(req_ready == 1'b1, "R11 req_ready in reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // isolated sweep over channels and both resolutions: R1 R5 R6 R7
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 2; r++) begin
        issue(3'(c), r[0], c[0], 2'(c >> 1) ^ {1'b0, r[0]});
        wait_idle();
        chk(frame_edges[nframes-1] == (r ? 20 : 24), r ? "R6 8-bit frame length" : "R5 12-bit frame length",
            frame_edges[nframes-1], r ? 20 : 24);
      end
    end

    // R8 start while busy is ignored
    issue(3'd2, 1'b0, 1'b1, 2'd3);
    repeat (300) @(negedge clk);
    chk(req_ready == 1'b0, "R8 req_ready low mid-frame", req_ready, 0);
    chan = 3'd5; res8 = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk(frame_edges[nframes-1] == 24, "R8 frame length after ignored start", frame_edges[nframes-1], 24);
    chk(nrcv == nissued, "R8 command count after ignored start", nrcv, nissued);

    // R10 overlap enabled, single request
    overlap_en = 1'b1;
    issue(3'd6, 1'b0, 1'b0, 2'd1);
    wait_idle();
    chk(frame_edges[nframes-1] == 24, "R10 lone overlapped frame length", frame_edges[nframes-1], 24);

    // R9 back-to-back run with mixed resolutions
    m[0] = 0; m[1] = 0; m[2] = 1; m[3] = 0; m[4] = 1;
    for (int k = 0; k < 5; k++) issue(3'(k + 1), m[k][0], 1'b1, 2'(k));
    wait_idle();
    sum = 20;
    for (int k = 0; k < 4; k++) sum += m[k] ? 11 : 15;
    chk(frame_edges[nframes-1] == sum, "R9 overlapped frame length", frame_edges[nframes-1], sum);
    for (int k = nissued - 4; k < nissued; k++) begin
      int gap;
      gap = exp_m8[k-1] ? 12 : 16;
      chk(rcv_frame[k] == rcv_frame[k-1], "R9 cs_n held across overlap", rcv_frame[k], rcv_frame[k-1]);
      chk(rcv_edge[k] - rcv_edge[k-1] == gap - 1, "R9 leading-bit spacing",
          rcv_edge[k] - rcv_edge[k-1], gap - 1);
    end
    overlap_en = 1'b0;
    repeat (10) @(negedge clk);

    // per-command checks: R1 decoded byte, R5 R6 R7 result value
    chk(nrcv == nissued, "R1 commands seen by converter", nrcv, nissued);
    chk(nres == nissued, "R7 result strobes", nres, nissued);
    for (int i = 0; i < nissued; i++) begin
      logic [11:0] v, e;
      v = mval(i);
      e = exp_m8[i] ? {v[7:0], 4'h0} : v;
      chk(rcv_cmd[i] == exp_cmd[i], "R1 command byte", rcv_cmd[i], exp_cmd[i]);
      chk(res_got[i] == e, exp_m8[i] ? "R6 R7 8-bit result" : "R5 R7 12-bit result", res_got[i], e);
    end
    chk(v_r2 == 0, "R2 clock level or idle violations", v_r2, 0);
    chk(v_r3 == 0, "R3 select-to-clock violations", v_r3, 0);
    chk(v_r4 == 0, "R4 data setup/hold violations", v_r4, 0);
    chk(v_r7 == 0, "R7 strobe longer than one cycle", v_r7, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule